// File: doc/BRIEF.md
# Hot-plug interrupt locator aggregator

This block collects the pending hot-plug events of a set of slots, plus a command-completion flag, into one locator word, and turns that word into an interrupt request. Each slot keeps a latch of five event kinds (card presence, isolated fault, attention button, retention latch, connected fault) that hardware sets and software clears by writing ones, and a mask with one disable bit per event kind. A small control register holds the global interrupt disable, the command-interrupt disable and the command-detected flag.

The locator has one bit per slot, placed at the slot index plus one, and bit 0 for command completion. When the locator is nonzero and the global disable is clear, the computed interrupt level is high. With message-signalled interrupts off, that level drives the level output directly. With them on, a notifier state machine records the last level and raises a one-cycle request pulse whenever the computed level differs from the recorded one. The notifier has two states, NT_LOW and NT_HIGH, and three transitions: T_RISE (NT_LOW to NT_HIGH when the level is high), T_FALL (NT_HIGH to NT_LOW when the level is low) and T_RESTORE (any state to NT_LOW when the restore input is high, which takes priority). A restore therefore makes a pending interrupt notify again.

Software writes go through one port. `wr_kind` selects the target: 0 control, 1 slot event latch (write-one-to-clear), 2 slot mask, 3 nothing. For the control target, `wr_data[0]` is the global interrupt disable, `wr_data[1]` the command-interrupt disable, and `wr_data[2]` clears command-detected when written as 1. For the latch and mask targets, `wr_data[4:0]` follows the event order presence bit 0, isolated fault bit 1, button bit 2, latch bit 3, connected fault bit 4. `evt_set` carries five bits per slot in the same order, slot s at bits [5s+4:5s].

Top module: `hpl_locator_agg`

## Requirements
- R1: After reset, locator, irq_level and msi_pulse are 0, both control disables are 1, command-detected is 0, every slot mask is 5'h1F, and the notifier is in NT_LOW. So events alone raise no locator bit.
- R2: Locator bit s+1 is 1 exactly when the AND of slot s's latch with the inverse of its mask is nonzero, in the cycle after the register update.
- R3: Locator bit 0 is 1 exactly when command-detected is 1 and the command-interrupt disable is 0.
- R4: The computed level is 1 when the global disable is 0 and the locator is nonzero. When msi_en is 0, irq_level equals that level. When msi_en is 1, irq_level is 0.
- R5: msi_pulse is 1 in a cycle exactly when msi_en is 1 and the computed level differs from the recorded level. Every clock edge records the current level (T_RISE/T_FALL), whatever msi_en is.
- R6: A latch write clears exactly the latch bits written as 1. Bits written as 0 are unchanged, and a write of all zeros has no effect.
- R7: A control write loads both disables from wr_data[1:0] and clears command-detected if wr_data[2] is 1. cmd_done sets command-detected.
- R8: When a hardware set and a software clear hit the same bit in the same cycle, the set wins. This holds for both slot events and command-detected.
- R9: restore forces the notifier to NT_LOW (T_RESTORE). If the level is high with msi_en 1, msi_pulse is 1 in the following cycle.
- R10: Writes with wr_kind 3, or with wr_slot at or above the slot count, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_en | input | 1 | Select message-signalled notification instead of level output |
| restore | input | 1 | Forget the recorded level (after state restore) |
| cmd_done | input | 1 | Command completion, sets command-detected |
| evt_set | input | NSLOTS*5 | Per-slot event set strobes |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Write target: 0 control, 1 latch, 2 mask, 3 none |
| wr_slot | input | SLOT_W | Slot index for latch/mask writes |
| wr_data | input | 5 | Write data |
| locator | output | NSLOTS+1 | Interrupt locator word |
| irq_level | output | 1 | Level interrupt output |
| msi_pulse | output | 1 | One-cycle notification request |

## Verification
The assertions assume that evt_set, cmd_done, restore and the write fields are stable around each rising edge, and that wr_slot is inside its declared width. The stimulus drives every input only on falling edges and returns every strobe to zero after one cycle. The recording assertion lets restore interrupt it, because the stimulus also asserts restore while an interrupt is pending. The sweep runs every mask against every event pattern on every slot of a three-slot build. It also issues writes to slot index 3, which is outside that build, to exercise the ignore rule.

// File: rtl/hpl_pkg.sv
`timescale 1ns/1ps
package hpl_pkg;
    localparam int EVT_W = 5;
    localparam int CTRL_W = 3;

    typedef enum logic [1:0] {
        WK_CTRL  = 2'd0,
        WK_LATCH = 2'd1,
        WK_MASK  = 2'd2,
        WK_NONE  = 2'd3
    } wr_kind_e;

    typedef enum logic {
        NT_LOW  = 1'b0,
        NT_HIGH = 1'b1
    } nt_state_e;
endpackage

// File: rtl/hpl_slot.sv
`timescale 1ns/1ps
module hpl_slot
    import hpl_pkg::*;
#(
    parameter int SLOT_W  = 2,
    parameter int SLOT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_set,
    input  logic              wr_en,
    input  wr_kind_e          wr_kind,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [EVT_W-1:0]  wr_data,
    output logic              pending
);
    localparam logic [SLOT_W-1:0] MY_IDX = SLOT_W'(SLOT_ID);

    logic [EVT_W-1:0] latch_q;
    logic [EVT_W-1:0] mask_q;
    logic             hit;
    logic             clr_hit;
    logic             mask_hit;
    logic [EVT_W-1:0] clr_bits;

    always_comb begin
        hit      = wr_en && (wr_slot == MY_IDX);
        clr_hit  = hit && (wr_kind == WK_LATCH);
        mask_hit = hit && (wr_kind == WK_MASK);
        clr_bits = clr_hit ? wr_data : '0;
    end

    // set has priority over a same-cycle software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            mask_q  <= '1;
        end else begin
            latch_q <= (latch_q & ~clr_bits) | evt_set;
            if (mask_hit) begin
                mask_q <= wr_data;
            end
        end
    end

    assign pending = |(latch_q & ~mask_q);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((latch_q & $past(evt_set)) == $past(evt_set)));

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && (evt_set == '0)) |=> ((latch_q & $past(wr_data)) == '0));

    a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_hit |=> $stable(mask_q));
endmodule

// File: rtl/hpl_ctrl.sv
`timescale 1ns/1ps
module hpl_ctrl
    import hpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  wr_kind_e          wr_kind,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              cmd_done,
    output logic              int_dis,
    output logic              cmd_int_dis,
    output logic              cmd_det
);
    logic ctl_hit;
    logic det_clr;

    always_comb begin
        ctl_hit = wr_en && (wr_kind == WK_CTRL);
        det_clr = ctl_hit && wr_data[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_dis     <= 1'b1;
            cmd_int_dis <= 1'b1;
            cmd_det     <= 1'b0;
        end else begin
            if (ctl_hit) begin
                int_dis     <= wr_data[0];
                cmd_int_dis <= wr_data[1];
            end
            cmd_det <= (cmd_det && !det_clr) || cmd_done;
        end
    end

    a_r7_cmd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> cmd_det);

    a_r7_dis_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_hit |=> ($stable(int_dis) && $stable(cmd_int_dis)));
endmodule

// File: rtl/hpl_notify.sv
`timescale 1ns/1ps
module hpl_notify
    import hpl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic msi_en,
    input  logic restore,
    output logic irq_level,
    output logic msi_pulse
);
    nt_state_e state_q;
    nt_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NT_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // T_RESTORE has priority, then T_RISE / T_FALL
    always_comb begin
        state_d = state_q;
        if (restore) begin
            state_d = NT_LOW;
        end else begin
            unique case (state_q)
                NT_LOW:  if (level)  state_d = NT_HIGH;
                NT_HIGH: if (!level) state_d = NT_LOW;
                default: state_d = NT_LOW;
            endcase
        end
    end

    always_comb begin
        irq_level = 1'b0;
        msi_pulse = 1'b0;
        unique case (state_q)
            NT_LOW:  msi_pulse = msi_en && level;
            NT_HIGH: msi_pulse = msi_en && !level;
            default: msi_pulse = 1'b0;
        endcase
        irq_level = !msi_en && level;
    end

    a_r5_records_level: assert property (@(posedge clk) disable iff (!rst_n)
        !restore |=> ((state_q == NT_HIGH) == $past(level)));

    a_r9_restore_low: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (state_q == NT_LOW));
endmodule

// File: rtl/hpl_locator_agg.sv
`timescale 1ns/1ps
module hpl_locator_agg
    import hpl_pkg::*;
#(
    parameter int NSLOTS = 6,
    localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    msi_en,
    input  logic                    restore,
    input  logic                    cmd_done,
    input  logic [NSLOTS*EVT_W-1:0] evt_set,
    input  logic                    wr_en,
    input  logic [1:0]              wr_kind,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic [EVT_W-1:0]        wr_data,
    output logic [NSLOTS:0]         locator,
    output logic                    irq_level,
    output logic                    msi_pulse
);
    wr_kind_e          kind;
    logic [NSLOTS-1:0] slot_pend;
    logic              int_dis;
    logic              cmd_int_dis;
    logic              cmd_det;
    logic              level;

    assign kind = wr_kind_e'(wr_kind);

    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
        hpl_slot #(
            .SLOT_W  (SLOT_W),
            .SLOT_ID (s)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_set (evt_set[s*EVT_W +: EVT_W]),
            .wr_en   (wr_en),
            .wr_kind (kind),
            .wr_slot (wr_slot),
            .wr_data (wr_data),
            .pending (slot_pend[s])
        );
    end

    hpl_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_kind     (kind),
        .wr_data     (wr_data[CTRL_W-1:0]),
        .cmd_done    (cmd_done),
        .int_dis     (int_dis),
        .cmd_int_dis (cmd_int_dis),
        .cmd_det     (cmd_det)
    );

    always_comb begin
        locator = {slot_pend, (cmd_det && !cmd_int_dis)};
        level   = !int_dis && (locator != '0);
    end

    hpl_notify u_notify (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (level),
        .msi_en    (msi_en),
        .restore   (restore),
        .irq_level (irq_level),
        .msi_pulse (msi_pulse)
    );

    a_r4_level_needs_locator: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level |-> (locator != '0));

    a_r4_exclusive_modes: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_level && msi_pulse));
endmodule

// File: tb/sim_hpl_locator_agg.sv
`timescale 1ns/1ps
module sim_hpl_locator_agg;
    localparam int NS = 3;
    localparam int EW = 5;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msi_en = 1'b0;
    logic restore = 1'b0;
    logic cmd_done = 1'b0;
    logic [NS*EW-1:0] evt_set = '0;
    logic wr_en = 1'b0;
    logic [1:0] wr_kind = 2'd0;
    logic [SW-1:0] wr_slot = '0;
    logic [EW-1:0] wr_data = '0;
    logic [NS:0] locator;
    logic irq_level;
    logic msi_pulse;

    hpl_locator_agg #(.NSLOTS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .restore(restore),
        .cmd_done(cmd_done), .evt_set(evt_set), .wr_en(wr_en),
        .wr_kind(wr_kind), .wr_slot(wr_slot), .wr_data(wr_data),
        .locator(locator), .irq_level(irq_level), .msi_pulse(msi_pulse)
    );

    always #2.5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [EW-1:0] m_latch [NS];
    logic [EW-1:0] m_mask [NS];
    logic m_idis, m_cdis, m_cdet, m_rec;

    function automatic logic [NS:0] exp_loc();
        logic [NS:0] l;
        l[0] = m_cdet && !m_cdis;
        for (int s = 0; s < NS; s++) l[s+1] = |(m_latch[s] & ~m_mask[s]);
        return l;
    endfunction

    function automatic logic exp_lvl();
        return !m_idis && (exp_loc() != '0);
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_latch[s] = '0;
            m_mask[s] = '1;
        end
        m_idis = 1'b1; m_cdis = 1'b1; m_cdet = 1'b0; m_rec = 1'b0;
    endtask

    task automatic model_edge();
        logic lv;
        logic [EW-1:0] clr;
        lv = exp_lvl();
        m_rec = restore ? 1'b0 : lv;
        for (int s = 0; s < NS; s++) begin
            clr = (wr_en && wr_kind == 2'd1 && int'(wr_slot) == s) ? wr_data : '0;
            m_latch[s] = (m_latch[s] & ~clr) | evt_set[s*EW +: EW];
            if (wr_en && wr_kind == 2'd2 && int'(wr_slot) == s) m_mask[s] = wr_data;
        end
        m_cdet = (m_cdet && !(wr_en && wr_kind == 2'd0 && wr_data[2])) || cmd_done;
        if (wr_en && wr_kind == 2'd0) begin
            m_idis = wr_data[0];
            m_cdis = wr_data[1];
        end
    endtask

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic check_outputs(string t);
        logic lv;
        lv = exp_lvl();
        chk({t, " locator"}, 32'(locator), 32'(exp_loc()));
        chk({t, " irq_level"}, 32'(irq_level), 32'(!msi_en && lv));
        chk({t, " msi_pulse"}, 32'(msi_pulse), 32'(msi_en && (lv != m_rec)));
    endtask

    task automatic step(string t);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_outputs(t);
        restore = 1'b0; cmd_done = 1'b0; wr_en = 1'b0; evt_set = '0;
    endtask

    task automatic wr(logic [1:0] k, int s, logic [EW-1:0] d, string t);
        wr_en = 1'b1; wr_kind = k; wr_slot = SW'(s); wr_data = d;
        step(t);
    endtask

    task automatic set_evt(int s, logic [EW-1:0] b, string t);
        evt_set[s*EW +: EW] = b;
        step(t);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check_outputs("R1 in reset");
        rst_n = 1'b1;
        step("R1 after reset");
        // R1: reset masks hide every event and command completion
        evt_set = '1; cmd_done = 1'b1;
        step("R1 masked events");
        chk("R1 locator zero", 32'(locator), 32'h0);
        for (int s = 0; s < NS; s++) wr(2'd1, s, 5'h1F, "R6 clear all");

        // R3/R4/R7: enable interrupts, pending command-detected appears
        wr(2'd0, 0, 5'b000, "R3 cmd bit shown");
        chk("R3 bit0 set", 32'(locator[0]), 32'h1);
        chk("R4 intx high", 32'(irq_level), 32'h1);
        wr(2'd0, 0, 5'b010, "R3 cmd int disabled");
        chk("R3 bit0 masked", 32'(locator[0]), 32'h0);
        wr(2'd0, 0, 5'b000, "R7 unmask again");
        wr(2'd0, 0, 5'b001, "R4 global disable");
        chk("R4 intx gated", 32'(irq_level), 32'h0);
        wr(2'd0, 0, 5'b100, "R7 w1c command");
        chk("R7 cmd cleared", 32'(locator[0]), 32'h0);
        // R8: cmd_done and clear in the same cycle
        cmd_done = 1'b1;
        wr(2'd0, 0, 5'b100, "R8 cmd set wins");
        chk("R8 cmd kept", 32'(locator[0]), 32'h1);
        wr(2'd0, 0, 5'b110, "R7 clear cmd");

        // R2 sweep: every mask against every event pattern on every slot
        for (int s = 0; s < NS; s++) begin
            for (int m = 0; m < 32; m++) begin
                wr(2'd2, s, EW'(m), "R2 mask write");
                for (int e = 1; e < 32; e++) begin
                    set_evt(s, EW'(e), "R2 sweep");
                    wr(2'd1, s, 5'h1F, "R6 sweep clear");
                end
            end
            wr(2'd2, s, 5'h00, "R2 unmask");
        end

        // R6: partial and zero clears
        set_evt(1, 5'b10101, "R6 set");
        wr(2'd1, 1, 5'b00000, "R6 zero write");
        chk("R6 zero write keeps", 32'(locator[2]), 32'h1);
        wr(2'd1, 1, 5'b00101, "R6 partial clear");
        chk("R6 partial keeps", 32'(locator[2]), 32'h1);
        wr(2'd1, 1, 5'b10000, "R6 final clear");
        chk("R6 now empty", 32'(locator[2]), 32'h0);

        // R8: slot set and clear same cycle
        evt_set[0*EW +: EW] = 5'b01000;
        wr(2'd1, 0, 5'b01000, "R8 slot set wins");
        chk("R8 slot kept", 32'(locator[1]), 32'h1);

        // R10: ignored writes
        wr(2'd1, 3, 5'h1F, "R10 out of range clear");
        wr(2'd2, 3, 5'h1F, "R10 out of range mask");
        wr(2'd3, 0, 5'h1F, "R10 kind none");
        chk("R10 still pending", 32'(locator[1]), 32'h1);
        wr(2'd1, 0, 5'h1F, "R6 clear slot0");

        // R5: message-signalled mode
        msi_en = 1'b1;
        step("R5 mode switch");
        set_evt(2, 5'b00010, "R5 rise pulse");
        chk("R5 rise", 32'(msi_pulse), 32'h1);
        step("R5 no repeat");
        chk("R5 single", 32'(msi_pulse), 32'h0);
        set_evt(0, 5'b00001, "R5 more events same level");
        chk("R5 no pulse", 32'(msi_pulse), 32'h0);
        // R9: restore while pending
        restore = 1'b1;
        step("R9 restore edge");
        chk("R9 fresh pulse", 32'(msi_pulse), 32'h1);
        step("R9 settled");
        wr(2'd1, 2, 5'h1F, "R5 partial drop");
        wr(2'd1, 0, 5'h1F, "R5 fall pulse");
        chk("R5 fall", 32'(msi_pulse), 32'h1);
        step("R5 idle");
        restore = 1'b1;
        step("R9 restore idle");
        chk("R9 no pulse idle", 32'(msi_pulse), 32'h0);
        // R5: level change while MSI is off is recorded
        msi_en = 1'b0;
        set_evt(1, 5'b00100, "R5 change while off");
        step("R5 off hold");
        msi_en = 1'b1;
        step("R5 recorded high");
        chk("R5 no stale pulse", 32'(msi_pulse), 32'h0);
        // R4: global disable drops level, pulses fall
        wr(2'd0, 0, 5'b001, "R4 disable in msi mode");
        chk("R4 fall on disable", 32'(msi_pulse), 32'h1);
        step("R4 quiet");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule